// File: doc/BRIEF.md
# Posted Interrupt Pending Bank

This block holds the pending state of up to twenty-four interrupt sources, grouped as three byte-wide registers on a simple register bus. Each bit position is bound to one hardware source, a reserved position, or nothing. Sources are either one-cycle pulses from on-chip units (timers, capture, serial transmit and receive, external pins, supply supervision), or raw port levels that are synchronised and reduced to rising edges, so a port posts once per edge. A posted bit stays set until software removes it.

Software reads a register to see every pending source in that byte. A write carries clear-or-set meaning per bit rather than plain storage: a zero removes the pending bit, and a one posts it only while a global software-interrupt enable is high. The block also gives the full pending vector and one registered request line, which is the OR of pending bits qualified by a per-bit mask input.

Top module: `irq_post_bank`

## Requirements
- R1: After reset every pending bit is 0, `irq_o` is 0 and all three registers read 0x00.
- R2: A read at address BASE+r (r = 0, 1, 2; BASE = 0xDA) returns register r, where register bit b is `pend_o[8*r+b]`; `bus_rdata` is combinational from `bus_addr`.
- R3: A write puts 0 in every pending bit whose written data bit is 0. While `swint_en` is 0, a written 1 leaves its bit unchanged.
- R4: While `swint_en` is 1, a written 1 sets its bit on the clock edge of the write, unless the bit is reserved.
- R5: Reserved positions always read 0 whatever is written or driven on `src_i`. By default the reserved positions are register 1 bits 3 and 4 and register 2 bits 7, 3, 2, 1 and 0 (valid mask 0x70E7FF over `pend_o`).
- R6: A pulse source held high for one cycle sets its bit on the next clock edge, and the bit stays set without further activity until software clears it.
- R7: Port sources (default `pend_o` positions 4, 7, 20, 21, 22; edge mask 0x700090) post on the third clock edge after a rising level, never earlier. A level held high does not post again after a clear, and a falling level posts nothing.
- R8: When a hardware set and a write of 0 reach the same bit on the same edge, the bit ends set.
- R9: `irq_o` equals, one cycle later, the OR over all bits of `pend_o & irq_mask_i`.
- R10: Writes to any address outside BASE..BASE+2 change no pending bit, and reads there return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register bus address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| swint_en | input | 1 | Global software-interrupt enable |
| src_i | input | 24 | Source per bit position: pulse or raw port level |
| irq_mask_i | input | 24 | Per-bit mask for the request line |
| pend_o | output | 24 | Pending vector, register r in bits 8r+7..8r |
| irq_o | output | 1 | Registered combined request |

## Verification
The bench builds the block with its defaults: three registers from 0xDA, valid mask 0x70E7FF and edge mask 0x700090. That small configuration lets it walk all twenty-four bit positions through software clear, enabled and disabled set, source activity, mask gating and the same-edge collision, so both source kinds and every reserved slot are covered. All 256 addresses are also swept, which reaches every out-of-range write and read.

// File: rtl/irq_post_pkg.sv
package irq_post_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 8;

    typedef logic [REG_W-1:0]  reg_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // Next value of one pending register given the write and hardware sets.
    function automatic reg_t next_pending(
        input reg_t cur,
        input logic wr_hit,
        input reg_t wdata,
        input logic sw_en,
        input reg_t hw_set,
        input reg_t valid
    );
        reg_t after_wr;
        if (wr_hit) begin
            after_wr = wdata & (cur | {REG_W{sw_en}});
        end else begin
            after_wr = cur;
        end
        return (after_wr | hw_set) & valid;
    endfunction
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= lvl_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise_o = sync_q & ~prev_q;
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
    import irq_post_pkg::*;
#(
    parameter reg_t VALID = '1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  reg_t wdata,
    input  logic sw_en,
    input  reg_t hw_set,
    output reg_t pend_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= next_pending(pend_q, wr_hit, wdata, sw_en, hw_set, VALID);
        end
    end
endmodule

// File: rtl/irq_post_bank.sv
module irq_post_bank
    import irq_post_pkg::*;
#(
    parameter int   BASE_ADDR  = 'hDA,
    parameter int   NUM_REGS   = 3,
    parameter logic [NUM_REGS*REG_W-1:0] VALID_MASK = 24'h70E7FF,
    parameter logic [NUM_REGS*REG_W-1:0] EDGE_MASK  = 24'h700090
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_wr,
    input  logic [REG_W-1:0]          bus_wdata,
    output logic [REG_W-1:0]          bus_rdata,
    input  logic                      swint_en,
    input  logic [NUM_REGS*REG_W-1:0] src_i,
    input  logic [NUM_REGS*REG_W-1:0] irq_mask_i,
    output logic [NUM_REGS*REG_W-1:0] pend_o,
    output logic                      irq_o
);
    localparam int TOTAL = NUM_REGS * REG_W;

    logic [TOTAL-1:0]    hw_raw;
    logic [TOTAL-1:0]    hw_set;
    logic [NUM_REGS-1:0] hit;
    logic                irq_q;

    // Per-bit source conditioning: edge detector for port levels, pass for pulses.
    for (genvar i = 0; i < TOTAL; i++) begin : g_src
        if (EDGE_MASK[i]) begin : g_edge
            irq_edge_sync u_sync (
                .clk    (clk),
                .rst_n  (rst_n),
                .lvl_i  (src_i[i]),
                .rise_o (hw_raw[i])
            );
        end else begin : g_pulse
            assign hw_raw[i] = src_i[i];
        end
    end

    assign hw_set = hw_raw & VALID_MASK;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        assign hit[r] = (bus_addr == ADDR_W'(BASE_ADDR + r));

        irq_pend_reg #(
            .VALID (VALID_MASK[r*REG_W +: REG_W])
        ) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_hit (bus_wr & hit[r]),
            .wdata  (bus_wdata),
            .sw_en  (swint_en),
            .hw_set (hw_set[r*REG_W +: REG_W]),
            .pend_q (pend_o[r*REG_W +: REG_W])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (hit[r]) begin
                bus_rdata = pend_o[r*REG_W +: REG_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(pend_o & irq_mask_i);
        end
    end

    assign irq_o = irq_q;
endmodule

module irq_post_bank_chk
    import irq_post_pkg::*;
#(
    parameter int BASE_ADDR = 'hDA,
    parameter int NUM_REGS  = 3,
    parameter logic [NUM_REGS*REG_W-1:0] VALID_MASK = 24'h70E7FF
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic                      bus_wr,
    input logic [REG_W-1:0]          bus_wdata,
    input logic [REG_W-1:0]          bus_rdata,
    input logic                      swint_en,
    input logic [NUM_REGS*REG_W-1:0] irq_mask_i,
    input logic [NUM_REGS*REG_W-1:0] pend_o,
    input logic                      irq_o,
    input logic [NUM_REGS*REG_W-1:0] hw_set
);
    logic outside;
    assign outside = (int'(bus_addr) < BASE_ADDR) || (int'(bus_addr) >= BASE_ADDR + NUM_REGS);

    // R5: reserved positions never show pending
    a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o & ~VALID_MASK) == '0);

    // R9: request line follows masked pending one cycle later
    a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_o == $past(|(pend_o & irq_mask_i)));

    // R10: outside addresses read zero
    a_r10_outside_read: assert property (@(posedge clk) disable iff (!rst_n)
        outside |-> bus_rdata == '0);

    // R6: no write and no hardware set keeps the vector
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr || outside) && hw_set == '0 |=> $stable(pend_o));

    // R8: hardware sets always land
    a_r8_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pend_o & $past(hw_set)) == $past(hw_set));

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_chk
        // R3: written zeros clear when no hardware set collides
        a_r3_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
            bus_wr && bus_addr == ADDR_W'(BASE_ADDR + r) && hw_set[r*REG_W +: REG_W] == '0
            |=> (pend_o[r*REG_W +: REG_W] & ~$past(bus_wdata)) == '0);

        // R4: enabled ones post on valid bits
        a_r4_sw_post: assert property (@(posedge clk) disable iff (!rst_n)
            bus_wr && bus_addr == ADDR_W'(BASE_ADDR + r) && swint_en
            |=> (pend_o[r*REG_W +: REG_W] & $past(bus_wdata))
                == ($past(bus_wdata) & VALID_MASK[r*REG_W +: REG_W]));
    end
endmodule

bind irq_post_bank irq_post_bank_chk #(
    .BASE_ADDR  (BASE_ADDR),
    .NUM_REGS   (NUM_REGS),
    .VALID_MASK (VALID_MASK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .swint_en   (swint_en),
    .irq_mask_i (irq_mask_i),
    .pend_o     (pend_o),
    .irq_o      (irq_o),
    .hw_set     (hw_set)
);

// File: tb/sim_irq_post_bank.sv
module sim_irq_post_bank;
    localparam int          NREG  = 3;
    localparam int          BASE  = 'hDA;
    localparam logic [23:0] VMASK = 24'h70E7FF;
    localparam logic [23:0] EMASK = 24'h700090;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        swint_en = 1'b0;
    logic [23:0] src_i = '0;
    logic [23:0] irq_mask_i = '0;
    logic [23:0] pend_o;
    logic        irq_o;

    int          errs = 0;
    int          checks = 0;
    logic [23:0] exp_p = '0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    irq_post_bank u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .swint_en   (swint_en),
        .src_i      (src_i),
        .irq_mask_i (irq_mask_i),
        .pend_o     (pend_o),
        .irq_o      (irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Model of R3/R4/R5 applied to the expected vector.
    task automatic wr_reg(input int r, input logic [7:0] d);
        bus_addr  = 8'(BASE + r);
        bus_wdata = d;
        bus_wr    = 1'b1;
        tick();
        bus_wr    = 1'b0;
        for (int b = 0; b < 8; b++) begin
            if (!d[b]) exp_p[r*8+b] = 1'b0;
            else if (swint_en && VMASK[r*8+b]) exp_p[r*8+b] = 1'b1;
        end
    endtask

    task automatic rd_chk(input string tag, input int r);
        bus_addr = 8'(BASE + r);
        #1;
        chk(tag, 32'(bus_rdata), 32'(exp_p[r*8 +: 8]));
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 pend", 32'(pend_o), 0);
        chk("R1 irq", 32'(irq_o), 0);
        for (int r = 0; r < NREG; r++) rd_chk("R1 read", r);

        for (int r = 0; r < NREG; r++) begin
            for (int b = 0; b < 8; b++) begin
                automatic int   i   = r*8 + b;
                automatic logic isv = VMASK[i];
                automatic logic ise = EMASK[i];
                automatic logic [7:0] one = 8'(1 << b);

                swint_en = 1'b0;
                wr_reg(r, 8'h00);
                wr_reg(r, one);
                chk("R3 one without enable", 32'(pend_o), 32'(exp_p));
                swint_en = 1'b1;
                wr_reg(r, one);
                chk("R4 enabled post", 32'(pend_o), 32'(exp_p));
                rd_chk("R2 read back", r);
                if (!isv) chk("R5 reserved after write", 32'(pend_o[i]), 0);
                swint_en = 1'b0;
                wr_reg(r, 8'hFF);
                chk("R3 ones keep", 32'(pend_o), 32'(exp_p));
                wr_reg(r, ~one);
                chk("R3 zero clears", 32'(pend_o), 32'(exp_p));

                if (ise) begin
                    src_i[i] = 1'b1;
                    tick();
                    tick();
                    chk("R7 not early", 32'(pend_o[i]), 0);
                    tick();
                    exp_p[i] = isv;
                    chk("R7 edge posts", 32'(pend_o), 32'(exp_p));
                end else begin
                    src_i[i] = 1'b1;
                    tick();
                    src_i[i] = 1'b0;
                    exp_p[i] = isv;
                    chk(isv ? "R6 pulse posts" : "R5 reserved source", 32'(pend_o), 32'(exp_p));
                end
                repeat (3) tick();
                chk("R6 holds", 32'(pend_o), 32'(exp_p));

                irq_mask_i = 24'(1) << i;
                tick();
                chk("R9 irq masked in", 32'(irq_o), 32'(exp_p[i]));
                irq_mask_i = ~(24'(1) << i);
                tick();
                chk("R9 irq masked out", 32'(irq_o), 0);
                irq_mask_i = '0;

                wr_reg(r, 8'h00);
                chk("R3 clear after source", 32'(pend_o), 32'(exp_p));
                if (ise) begin
                    repeat (3) tick();
                    chk("R7 level no repost", 32'(pend_o[i]), 0);
                    src_i[i] = 1'b0;
                    repeat (4) tick();
                    chk("R7 fall no post", 32'(pend_o[i]), 0);
                end

                if (isv) begin
                    if (ise) begin
                        src_i[i] = 1'b1;
                        tick();
                        tick();
                        wr_reg(r, 8'h00);
                        exp_p[i] = 1'b1;
                        chk("R8 edge beats clear", 32'(pend_o), 32'(exp_p));
                        src_i[i] = 1'b0;
                        repeat (3) tick();
                    end else begin
                        src_i[i] = 1'b1;
                        wr_reg(r, 8'h00);
                        src_i[i] = 1'b0;
                        exp_p[i] = 1'b1;
                        chk("R8 pulse beats clear", 32'(pend_o), 32'(exp_p));
                    end
                    wr_reg(r, 8'h00);
                    chk("R8 later clear", 32'(pend_o), 32'(exp_p));
                end
            end
        end

        // R10 sweep of every address
        swint_en = 1'b1;
        for (int r = 0; r < NREG; r++) wr_reg(r, 8'hFF);
        chk("R5 all ones", 32'(pend_o), 32'(VMASK));
        for (int a = 0; a < 256; a++) begin
            if (a < BASE || a >= BASE + NREG) begin
                bus_addr  = 8'(a);
                bus_wdata = 8'h00;
                bus_wr    = 1'b1;
                tick();
                bus_wr    = 1'b0;
                #1;
                chk("R10 outside read", 32'(bus_rdata), 0);
            end
        end
        chk("R10 outside writes ignored", 32'(pend_o), 32'(exp_p));
        for (int r = 0; r < NREG; r++) rd_chk("R2 final read", r);
        irq_mask_i = '1;
        tick();
        chk("R9 irq all", 32'(irq_o), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule